// File: doc/BRIEF.md
# Inter-Processor Mailbox

This block carries 32-bit messages from one processor to another through a set of small hardware queues. Software places a message by writing a queue's message register and takes the oldest one out by reading that same register. Read-only registers give each queue's fill level and a full flag. The sender can poll the full flag, and the receiver can poll the fill level.

Several users, typically one per processor, each own a register set for interrupts. Each set has a status word, an enable word and an enable-clear word. Every queue owns two adjacent bits in these words: one for "a message arrived" and one for "space opened up". Status bits latch events and are cleared by writing ones. Enable bits are set by writing ones to the enable word and cleared by writing ones to the enable-clear word, so two agents can change enables without a read-modify-write. Each user gets one interrupt line, which is high while any of its enabled status bits is pending.

Access is through a simple register bus that never stalls. A request is accepted in the cycle `req_valid` is high. A read answers one cycle later with `rsp_valid` and `rsp_data`. Since there is no `ready`, the bus applies no back-pressure. The requester may issue one request every cycle and must take each response in the cycle it is presented.

Top module: `ipc_mailbox`

## Requirements
- R1: Offset 0x000 reads the revision word, with the major number in bits [7:4], the minor number in bits [3:0] and zeros above. Writes to it change nothing.
- R2: A write to offset 0x040 + 4*m appends the data word to queue m when the queue holds fewer than 4 words. A read of that offset returns and removes the oldest word, so words leave in the order they arrived.
- R3: A write to a queue that already holds 4 words is dropped. The contents, fill level and status bits stay as they were.
- R4: A read of an empty queue's message offset returns 0 and changes no queue contents, fill level or status bit.
- R5: Offset 0x080 + 4*m reads 1 when queue m holds 4 words and 0 otherwise. Offset 0x0C0 + 4*m reads the number of words in queue m (0 to 4). After reset every queue is empty.
- R6: In each user's status word (offset 0x104 + 0x10*u), bit 2*m is set in every user when a word is accepted into queue m. Bit 2*m+1 is set in every user when a word is removed from queue m. After reset all status bits are 0.
- R7: Writing the status word clears each bit written as 1 and leaves each bit written as 0 unchanged. A read in the next request already returns the cleared value.
- R8: Writing the enable word (offset 0x108 + 0x10*u) sets each bit written as 1 and leaves bits written as 0 unchanged. Reads return the enable bits, which are 0 after reset.
- R9: Writing the enable-clear word (offset 0x10C + 0x10*u) clears each enable bit written as 1 and leaves bits written as 0 unchanged. A read of it returns the enable bits.
- R10: `irq[u]` is high exactly when some status bit of user u and the same enable bit are both 1. It follows register changes in the cycle after the access and does not change while the bus is idle.
- R11: Every read request is answered by `rsp_valid` high for exactly one cycle, in the following cycle. `rsp_valid` stays low after a cycle with no read request.
- R12: Offsets that are not word-aligned, lie at or beyond 0x120, or match no register read as 0. Writes to them, and to the read-only full and count registers, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_data | output | 32 | Read data |
| irq | output | 2 | Per-user interrupt, high while an enabled event is pending |

## Verification
The assertions assume that reset is held low over the first clock edges. They also assume at most one request per cycle, with the request signals at known values whenever reset is released. Their claims about response data hold only because a read's answer depends solely on state from before that same request. The stimulus meets these assumptions in the following way. It changes the request signals only on falling edges, it holds `req_valid` for a single cycle per access, and it leaves idle cycles between accesses. It draws random traffic only from mapped offsets and a fixed set of unmapped ones, and it fills queues well past full and drains them well past empty.

// File: rtl/ipc_mbox_pkg.sv
`timescale 1ns/1ps
package ipc_mbox_pkg;

  // Register layout: software on the far side decodes these offsets.
  localparam int MSG_BASE    = 'h040;
  localparam int FULL_BASE   = 'h080;
  localparam int CNT_BASE    = 'h0C0;
  localparam int USR_BASE    = 'h100;
  localparam int USR_STRIDE  = 'h010;
  localparam int USR_STS_OFS = 'h4;
  localparam int USR_EN_OFS  = 'h8;
  localparam int USR_CLR_OFS = 'hC;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_REV,
    RK_MSG,
    RK_FULL,
    RK_CNT,
    RK_STS,
    RK_EN,
    RK_CLR
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [7:0] idx;
  } reg_sel_t;

endpackage

// File: rtl/ipc_mbox_decode.sv
`timescale 1ns/1ps
module ipc_mbox_decode
  import ipc_mbox_pkg::*;
#(
  parameter int AW = 12,
  parameter int NQ = 4,
  parameter int NU = 2
) (
  input  logic [AW-1:0] addr,
  output reg_sel_t      sel
);

  localparam logic [AW-1:0] MSG_LO  = AW'(MSG_BASE);
  localparam logic [AW-1:0] MSG_HI  = AW'(MSG_BASE + 4 * NQ);
  localparam logic [AW-1:0] FULL_LO = AW'(FULL_BASE);
  localparam logic [AW-1:0] FULL_HI = AW'(FULL_BASE + 4 * NQ);
  localparam logic [AW-1:0] CNT_LO  = AW'(CNT_BASE);
  localparam logic [AW-1:0] CNT_HI  = AW'(CNT_BASE + 4 * NQ);
  localparam logic [AW-1:0] USR_LO  = AW'(USR_BASE);
  localparam logic [AW-1:0] USR_HI  = AW'(USR_BASE + USR_STRIDE * NU);

  logic [AW-1:0] ofs;

  always_comb begin
    sel.kind = RK_NONE;
    sel.idx  = '0;
    ofs      = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr == '0) begin
        sel.kind = RK_REV;
      end else if (addr >= MSG_LO && addr < MSG_HI) begin
        ofs      = addr - MSG_LO;
        sel.kind = RK_MSG;
        sel.idx  = 8'(ofs >> 2);
      end else if (addr >= FULL_LO && addr < FULL_HI) begin
        ofs      = addr - FULL_LO;
        sel.kind = RK_FULL;
        sel.idx  = 8'(ofs >> 2);
      end else if (addr >= CNT_LO && addr < CNT_HI) begin
        ofs      = addr - CNT_LO;
        sel.kind = RK_CNT;
        sel.idx  = 8'(ofs >> 2);
      end else if (addr >= USR_LO && addr < USR_HI) begin
        ofs     = addr - USR_LO;
        sel.idx = 8'(ofs >> 4);
        case (ofs[3:0])
          4'(USR_STS_OFS): sel.kind = RK_STS;
          4'(USR_EN_OFS):  sel.kind = RK_EN;
          4'(USR_CLR_OFS): sel.kind = RK_CLR;
          default:         sel.kind = RK_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/ipc_mbox_fifo.sv
`timescale 1ns/1ps
module ipc_mbox_fifo #(
  parameter  int DW    = 32,
  parameter  int DEPTH = 4,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          push_done,
  output logic          pop_done
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_done = push && (count != CW'(DEPTH));
  assign pop_done  = pop && (count != '0);
  assign head      = (count == '0) ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_done) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_done) wr_ptr <= step(wr_ptr);
      if (pop_done)  rd_ptr <= step(rd_ptr);
      case ({push_done, pop_done})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/ipc_mbox_user.sv
`timescale 1ns/1ps
module ipc_mbox_user #(
  parameter  int NQ = 4,
  localparam int EW = 2 * NQ
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] new_ev,
  input  logic [NQ-1:0] nf_ev,
  input  logic          sts_clr,
  input  logic          en_set,
  input  logic          en_clr,
  input  logic [EW-1:0] mask,
  output logic [EW-1:0] status,
  output logic [EW-1:0] enable,
  output logic          irq
);

  logic [EW-1:0] ev;

  for (genvar m = 0; m < NQ; m++) begin : g_pair
    assign ev[2*m]   = new_ev[m];
    assign ev[2*m+1] = nf_ev[m];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= (status & ~(sts_clr ? mask : '0)) | ev;
      if (en_set)      enable <= enable | mask;
      else if (en_clr) enable <= enable & ~mask;
    end
  end

  assign irq = |(status & enable);

endmodule

// File: rtl/ipc_mailbox.sv
`timescale 1ns/1ps
module ipc_mailbox
  import ipc_mbox_pkg::*;
#(
  parameter int          NQ        = 4,
  parameter int          NU        = 2,
  parameter int          DEPTH     = 4,
  parameter int          DW        = 32,
  parameter int          AW        = 12,
  parameter logic [3:0]  REV_MAJOR = 4'd2,
  parameter logic [3:0]  REV_MINOR = 4'd1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [NU-1:0] irq
);

  localparam int EW = 2 * NQ;
  localparam int CW = $clog2(DEPTH + 1);

  reg_sel_t               sel;
  logic                   rd_req, wr_req;
  logic [NQ-1:0][CW-1:0]  q_cnt;
  logic [NQ-1:0][DW-1:0]  q_head;
  logic [NQ-1:0]          q_new, q_nf;
  logic [NU-1:0][EW-1:0]  u_sts, u_en;
  logic [DW-1:0]          rd_mux;

  assign rd_req = req_valid && !req_write;
  assign wr_req = req_valid && req_write;

  ipc_mbox_decode #(.AW(AW), .NQ(NQ), .NU(NU)) u_dec (
    .addr (req_addr),
    .sel  (sel)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    logic hit;
    assign hit = (sel.kind == RK_MSG) && (sel.idx == 8'(q));
    ipc_mbox_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wr_req && hit),
      .push_data (req_wdata),
      .pop       (rd_req && hit),
      .head      (q_head[q]),
      .count     (q_cnt[q]),
      .push_done (q_new[q]),
      .pop_done  (q_nf[q])
    );
  end

  for (genvar u = 0; u < NU; u++) begin : g_user
    logic hit;
    assign hit = (sel.idx == 8'(u));
    ipc_mbox_user #(.NQ(NQ)) u_usr (
      .clk     (clk),
      .rst_n   (rst_n),
      .new_ev  (q_new),
      .nf_ev   (q_nf),
      .sts_clr (wr_req && hit && sel.kind == RK_STS),
      .en_set  (wr_req && hit && sel.kind == RK_EN),
      .en_clr  (wr_req && hit && sel.kind == RK_CLR),
      .mask    (req_wdata[EW-1:0]),
      .status  (u_sts[u]),
      .enable  (u_en[u]),
      .irq     (irq[u])
    );
  end

  always_comb begin
    rd_mux = '0;
    case (sel.kind)
      RK_REV: rd_mux = DW'({REV_MAJOR, REV_MINOR});
      RK_MSG: begin
        for (int i = 0; i < NQ; i++)
          if (sel.idx == 8'(i)) rd_mux = q_head[i];
      end
      RK_FULL: begin
        for (int i = 0; i < NQ; i++)
          if (sel.idx == 8'(i)) rd_mux = DW'(q_cnt[i] == CW'(DEPTH));
      end
      RK_CNT: begin
        for (int i = 0; i < NQ; i++)
          if (sel.idx == 8'(i)) rd_mux = DW'(q_cnt[i]);
      end
      RK_STS: begin
        for (int i = 0; i < NU; i++)
          if (sel.idx == 8'(i)) rd_mux = DW'(u_sts[i]);
      end
      RK_EN, RK_CLR: begin
        for (int i = 0; i < NU; i++)
          if (sel.idx == 8'(i)) rd_mux = DW'(u_en[i]);
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_data <= rd_mux;
    end
  end

endmodule

// File: rtl/ipc_mailbox_chk.sv
`timescale 1ns/1ps
module ipc_mailbox_chk #(
  parameter  int         NQ        = 4,
  parameter  int         NU        = 2,
  parameter  int         DEPTH     = 4,
  parameter  int         DW        = 32,
  parameter  int         AW        = 12,
  parameter  logic [3:0] REV_MAJOR = 4'd2,
  parameter  logic [3:0] REV_MINOR = 4'd1,
  localparam int         CW        = $clog2(DEPTH + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_write,
  input logic [AW-1:0]         req_addr,
  input logic                  rsp_valid,
  input logic [DW-1:0]         rsp_data,
  input logic [NU-1:0]         irq,
  input logic [NQ-1:0][CW-1:0] q_cnt
);

  localparam logic [AW-1:0] SPACE_END = AW'('h100 + 'h10 * NU);

  logic rd, wr;
  assign rd = req_valid && !req_write;
  assign wr = req_valid && req_write;

  a_r11_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);

  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);

  a_r1_revision: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && req_addr == '0) |=> rsp_data == DW'({REV_MAJOR, REV_MINOR}));

  a_r12_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (req_addr >= SPACE_END || req_addr[1:0] != 2'b00)) |=> rsp_data == '0);

  a_r10_idle_irq_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(irq));

  for (genvar q = 0; q < NQ; q++) begin : g_q
    a_r4_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && req_addr == AW'('h040 + 4 * q) && q_cnt[q] == '0)
        |=> (rsp_data == '0 && q_cnt[q] == '0));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && req_addr == AW'('h040 + 4 * q) && q_cnt[q] == CW'(DEPTH))
        |=> q_cnt[q] == CW'(DEPTH));

    a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      q_cnt[q] <= CW'(DEPTH));
  end

endmodule

bind ipc_mailbox ipc_mailbox_chk #(
  .NQ(NQ), .NU(NU), .DEPTH(DEPTH), .DW(DW), .AW(AW),
  .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .irq       (irq),
  .q_cnt     (q_cnt)
);

// File: tb/tb_ipc_mailbox.sv
`timescale 1ns/1ps
module tb_ipc_mailbox;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ipc_mailbox dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .irq(irq)
  );

  // Behavioural reference: 4 queues of depth 4, 2 users.
  int unsigned mq[4][$];
  logic [7:0]  mst[2];
  logic [7:0]  men[2];

  function automatic logic [1:0] model_irq();
    return {|(mst[1] & men[1]), |(mst[0] & men[0])};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step(input bit wr, input logic [11:0] a, input logic [31:0] d,
                            output logic [31:0] rv);
    int ai = int'(a);
    int kind = 0;
    int idx = 0;
    rv = '0;
    if (ai % 4 == 0) begin
      if (ai == 0) kind = 1;
      else if (ai >= 'h40 && ai < 'h50) begin kind = 2; idx = (ai - 'h40) / 4; end
      else if (ai >= 'h80 && ai < 'h90) begin kind = 3; idx = (ai - 'h80) / 4; end
      else if (ai >= 'hC0 && ai < 'hD0) begin kind = 4; idx = (ai - 'hC0) / 4; end
      else if (ai >= 'h100 && ai < 'h120) begin
        idx = (ai - 'h100) / 16;
        case ((ai - 'h100) % 16)
          4: kind = 5;
          8: kind = 6;
          12: kind = 7;
          default: kind = 0;
        endcase
      end
    end
    if (wr) begin
      case (kind)
        2: if (mq[idx].size() < 4) begin
             mq[idx].push_back(d);
             for (int u = 0; u < 2; u++) mst[u][2*idx] = 1'b1;
           end
        5: mst[idx] = mst[idx] & ~d[7:0];
        6: men[idx] = men[idx] | d[7:0];
        7: men[idx] = men[idx] & ~d[7:0];
        default: ;
      endcase
    end else begin
      case (kind)
        1: rv = 32'h21;
        2: if (mq[idx].size() > 0) begin
             rv = mq[idx].pop_front();
             for (int u = 0; u < 2; u++) mst[u][2*idx+1] = 1'b1;
           end
        3: rv = (mq[idx].size() == 4) ? 32'd1 : 32'd0;
        4: rv = 32'(mq[idx].size());
        5: rv = {24'h0, mst[idx]};
        6, 7: rv = {24'h0, men[idx]};
        default: rv = '0;
      endcase
    end
  endtask

  task automatic bus(input bit wr, input logic [11:0] a, input logic [31:0] d,
                     input string tag, output logic [31:0] got);
    logic [31:0] exp;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    #1;
    model_step(wr, a, d, exp);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    got = rsp_data;
    if (!wr) begin
      chk(rsp_valid === 1'b1, "R11", "rsp_valid after read", longint'(rsp_valid), 1);
      chk(rsp_data === exp, tag, $sformatf("read @%03h", a), longint'(rsp_data), longint'(exp));
    end else begin
      chk(rsp_valid === 1'b0, "R11", "rsp_valid after write", longint'(rsp_valid), 0);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    logic [31:0] g;
    bus(1'b1, a, d, tag, g);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    logic [31:0] g;
    bus(1'b0, a, 32'h0, tag, g);
  endtask

  // Interrupt lines compared with the reference on every clock (R10).
  always @(negedge clk) begin
    if (running && !done)
      chk(irq === model_irq(), "R10", "irq vs reference", longint'(irq), longint'(model_irq()));
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [11:0] UNMAPPED [8] = '{12'h004, 12'h050, 12'h090, 12'h100,
                                           12'h120, 12'h041, 12'h0FC, 12'h130};

  initial begin
    for (int u = 0; u < 2; u++) begin mst[u] = '0; men[u] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(irq === 2'b00, "R10", "irq after reset", longint'(irq), 0);
    chk(rsp_valid === 1'b0, "R11", "rsp_valid after reset", longint'(rsp_valid), 0);
    running = 1'b1;

    // R5 R6 R8: reset state of levels, flags, status and enables
    for (int q = 0; q < 4; q++) begin
      rd(12'(('hC0) + 4 * q), "R5");
      rd(12'(('h80) + 4 * q), "R5");
    end
    rd(12'h104, "R6"); rd(12'h114, "R6"); rd(12'h108, "R8"); rd(12'h118, "R8");

    // R1: revision, and writes to it are ignored
    rd(12'h000, "R1");
    wr(12'h000, 32'hFFFF_FFFF, "R1");
    rd(12'h000, "R1");

    // R2 R6: single message, event in both users
    wr(12'h040, 32'hCAFE_0001, "R2");
    rd(12'h0C0, "R5"); rd(12'h104, "R6"); rd(12'h114, "R6");

    // R2 R3 R5: fill queue 1 past full, then drain past empty (R4)
    for (int i = 0; i < 6; i++) begin
      wr(12'h044, 32'h1000 + 32'(i), "R3");
      rd(12'h0C4, "R5");
      rd(12'h084, "R5");
    end
    wr(12'h104, 32'h0000_000C, "R7");
    wr(12'h044, 32'hDEAD_BEEF, "R3");
    rd(12'h104, "R3");
    for (int i = 0; i < 6; i++) begin
      rd(12'h044, "R2");
      rd(12'h0C4, "R4");
    end
    wr(12'h104, 32'h0000_00FF, "R7");
    rd(12'h044, "R4");
    rd(12'h104, "R4");

    // R7: zeros leave bits, ones clear, immediate read-back
    wr(12'h048, 32'h77, "R6");
    wr(12'h114, 32'h0, "R7");
    rd(12'h114, "R7");
    wr(12'h114, 32'h10, "R7");
    rd(12'h114, "R7");

    // R8 R9 R10: enables set and clear by ones
    wr(12'h118, 32'h0000_0030, "R8");
    rd(12'h118, "R8");
    wr(12'h108, 32'h0000_0010, "R10");
    rd(12'h10C, "R9");
    wr(12'h11C, 32'h0000_0020, "R9");
    rd(12'h118, "R9");
    wr(12'h11C, 32'h0, "R9");
    rd(12'h11C, "R9");
    wr(12'h104, 32'h0000_0010, "R10");
    rd(12'h048, "R10");
    wr(12'h108, 32'h0000_0020, "R10");

    // R12: unmapped offsets and read-only registers
    wr(12'h04C, 32'h55, "R12");
    for (int i = 0; i < 8; i++) begin
      wr(UNMAPPED[i], 32'hFFFF_FFFF, "R12");
      rd(UNMAPPED[i], "R12");
    end
    wr(12'h08C, 32'h0, "R12");
    wr(12'h0CC, 32'h7, "R12");
    rd(12'h0CC, "R12"); rd(12'h08C, "R12"); rd(12'h104, "R12"); rd(12'h108, "R12");

    // Mixed traffic against the reference (R2 R3 R4 R6 R7 R8 R9)
    for (int n = 0; n < 1500; n++) begin
      int pick = $urandom_range(0, 9);
      int q = $urandom_range(0, 3);
      int u = $urandom_range(0, 1);
      logic [31:0] d = $urandom;
      case (pick)
        0, 1: wr(12'(('h40) + 4 * q), d, "R2");
        2, 3: rd(12'(('h40) + 4 * q), "R2");
        4: rd(12'(($urandom_range(0, 1) ? 'h80 : 'hC0) + 4 * q), "R5");
        5: wr(12'(('h104) + 16 * u), {24'h0, d[7:0]}, "R7");
        6: wr(12'(('h108) + 16 * u), {24'h0, d[7:0] & d[15:8]}, "R8");
        7: wr(12'(('h10C) + 16 * u), {24'h0, d[7:0]}, "R9");
        8: rd(12'(('h104) + 4 * $urandom_range(0, 2) + 16 * u), "R6");
        default: begin
          wr(UNMAPPED[q * 2 + u], d, "R12");
          rd(UNMAPPED[q * 2 + u], "R12");
        end
      endcase
    end

    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule